// File: doc/BRIEF.md
# Display Sink Capability Register File

This block stands in for the configuration space of an attached display sink, as the source sees it through an auxiliary-channel slave port. A host issues single-byte reads and writes over a simple request/acknowledge interface. A write carries one data byte and a read returns one. The map decodes 20 address bits, but only the lowest 1536 bytes have storage behind them. Reads anywhere else return zero, writes anywhere else are discarded, and both raise an error flag alongside the acknowledge.

After a synchronous reset the backed bytes hold a fixed image of an idle but fully trained sink. That image sets the capability revision, the maximum link rate, the lane count, the receiver-port flags and buffer size, and marks all four lanes as locked and aligned. Every other backed byte is cleared. The host may overwrite any backed byte, the preset ones included. A request is accepted in any cycle it is presented, and back-to-back requests are allowed.

Top module: `sink_cap_regs`

## Requirements
- R1: After reset, reads return these values: offset 0x000 = 0x10, 0x001 = 0x14, 0x002 = 0x04, 0x008 = 0x02, 0x009 = 0xFF, 0x202 = 0x77, 0x203 = 0x77, 0x204 = 0x01 and 0x205 = 0x01. In each of 0x202 and 0x203, bits 0/4 are clock recovery done, bits 1/5 are equalisation done and bits 2/6 are symbol lock, for the lower and upper lane of the pair.
- R2: After reset, every other backed offset in 0x000..0x5FF reads 0x00.
- R3: Each request (reqValid high at a rising edge) yields ackValid high in exactly the following cycle. ackValid is never high otherwise.
- R4: A read of a backed offset presents the stored byte on ackRdata in the acknowledge cycle, with ackErr low.
- R5: A write to a backed offset replaces the byte unconditionally, preset bytes included, and a later read returns the new value. Its acknowledge has ackErr low and ackRdata 0x00.
- R6: A read at offset 0x600 or above returns 0x00 with ackErr high.
- R7: A write at offset 0x600 or above changes no stored byte and raises ackErr.
- R8: A request with any address bit above bit 19 set counts as out of range, even if its low 20 bits fall inside the backed window.
- R9: ackErr is a single-cycle pulse and is high only together with ackValid.
- R10: A read issued in the cycle right after a write to the same offset returns the newly written byte.
- R11: Reset is synchronous and restores the full preset image, overriding earlier writes. A read issued in the first cycle after reset is released already sees the preset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | BUS_ADDR_W (24) | Byte address |
| reqWdata | input | 8 | Write data byte |
| ackValid | output | 1 | Acknowledge, one cycle after the request |
| ackRdata | output | 8 | Read data, valid during ackValid; 0x00 otherwise |
| ackErr | output | 1 | Out-of-range access, coincides with ackValid |

## Verification
A wrong preset or a stray write corrupts a stored byte, and it stays hidden until that offset is read. The bench therefore reads back every preset offset, the window edges, and the bytes that an out-of-range write could alias onto. A decode error shows up on the very next acknowledge, as a wrong ackErr or as non-zero data. A lost or duplicated acknowledge also shows one cycle after the request, because each access is checked in the cycle after it is issued.

// File: rtl/sink_cap_pkg.sv
package sink_cap_pkg;

  localparam int DATA_W = 8;

  // Strobes passed from the decode/control side to the storage side.
  typedef struct packed {
    logic wrStb;   // commit reqWdata to the indexed byte
    logic rdStb;   // capture the indexed byte as read data
  } cfgStrobe_t;

  // Reset image of the backed window; unlisted bytes are zero.
  function automatic logic [DATA_W-1:0] presetByte(input int unsigned idx);
    case (idx)
      32'h000: presetByte = 8'h10;  // capability revision
      32'h001: presetByte = 8'h14;  // max link rate code
      32'h002: presetByte = 8'h04;  // lane count
      32'h008: presetByte = 8'h02;  // receiver port flags
      32'h009: presetByte = 8'hFF;  // receiver buffer size
      32'h202: presetByte = 8'h77;  // lanes 0/1 trained
      32'h203: presetByte = 8'h77;  // lanes 2/3 trained
      32'h204: presetByte = 8'h01;  // interlane aligned
      32'h205: presetByte = 8'h01;  // port 0 in sync
      default: presetByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sink_cap_ctrl.sv
module sink_cap_ctrl
  import sink_cap_pkg::*;
#(
  parameter int BUS_ADDR_W = 24,
  parameter int WIN_BYTES  = 1536
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [BUS_ADDR_W-1:0] reqAddr,
  output cfgStrobe_t            stb,
  output logic                  ackValid,
  output logic                  ackErr
);

  // A full-width compare also rejects any bit above the 20-bit map.
  logic inWin;
  assign inWin = (reqAddr < BUS_ADDR_W'(WIN_BYTES));

  always_comb begin
    stb.wrStb = reqValid & reqWrite & inWin;
    stb.rdStb = reqValid & ~reqWrite & inWin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackValid <= 1'b0;
      ackErr   <= 1'b0;
    end else begin
      ackValid <= reqValid;
      ackErr   <= reqValid & ~inWin;
    end
  end

  // R3: every accepted request is acknowledged on the next cycle
  a_r3_ack_next: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> ackValid);
  // R3: no acknowledge without a request one cycle earlier
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !ackValid);
  // R9: error only alongside an acknowledge
  a_r9_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    ackErr |-> ackValid);
  // R8: bits above the 20-bit map force an error
  a_r8_high_bits: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqAddr >> 20) != 0) |=> ackErr);

endmodule

// File: rtl/sink_cap_store.sv
module sink_cap_store
  import sink_cap_pkg::*;
#(
  parameter int WIN_BYTES = 1536,
  localparam int IDX_W = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgStrobe_t        stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WIN_BYTES];

  // Synchronous reset loads the whole image in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_BYTES; i++) mem[i] <= presetByte(i);
    end else if (stb.wrStb) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (stb.rdStb) rdata <= mem[idx];
    else                rdata <= '0;
  end

  // R5: a committed write is visible in storage on the next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    stb.wrStb |=> (mem[$past(idx)] == $past(wdata)));
  // R6: without a backed read the data lane is zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !stb.rdStb |=> (rdata == '0));

endmodule

// File: rtl/sink_cap_regs.sv
module sink_cap_regs
  import sink_cap_pkg::*;
#(
  parameter int BUS_ADDR_W = 24,
  parameter int WIN_BYTES  = 1536,
  localparam int IDX_W = $clog2(WIN_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [BUS_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  ackValid,
  output logic [DATA_W-1:0]     ackRdata,
  output logic                  ackErr
);

  cfgStrobe_t stb;

  sink_cap_ctrl #(.BUS_ADDR_W(BUS_ADDR_W), .WIN_BYTES(WIN_BYTES)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .stb      (stb),
    .ackValid (ackValid),
    .ackErr   (ackErr)
  );

  sink_cap_store #(.WIN_BYTES(WIN_BYTES)) uStore (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .idx   (reqAddr[IDX_W-1:0]),
    .wdata (reqWdata),
    .rdata (ackRdata)
  );

  // R6: an out-of-range acknowledge never carries data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    ackErr |-> (ackRdata == '0));

endmodule

// File: tb/tb_sink_cap_regs.sv
`timescale 1ns/1ps
module tb_sink_cap_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ackValid;
  logic [7:0]  ackRdata;
  logic        ackErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sink_cap_regs dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ackValid(ackValid), .ackRdata(ackRdata), .ackErr(ackErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One access: issue at a falling edge, check the acknowledge a cycle later.
  task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] wd,
                        input logic [7:0] expD, input bit expE, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(ackValid == 1'b1, req, "ackValid", 32'(ackValid), 32'h1);
    check(ackRdata == expD, req, "ackRdata", 32'(ackRdata), 32'(expD));
    check(ackErr == expE, req, "ackErr", 32'(ackErr), 32'(expE));
  endtask

  // {write, addr, wdata, expected data, expected error}
  localparam int NV = 22;
  localparam logic [41:0] VECS [NV] = '{
    {1'b0, 24'h000000, 8'h00, 8'h10, 1'b0},  // R1
    {1'b0, 24'h000001, 8'h00, 8'h14, 1'b0},  // R1
    {1'b0, 24'h000002, 8'h00, 8'h04, 1'b0},  // R1
    {1'b0, 24'h000008, 8'h00, 8'h02, 1'b0},  // R1
    {1'b0, 24'h000009, 8'h00, 8'hFF, 1'b0},  // R1
    {1'b0, 24'h000202, 8'h00, 8'h77, 1'b0},  // R1
    {1'b0, 24'h000203, 8'h00, 8'h77, 1'b0},  // R1
    {1'b0, 24'h000204, 8'h00, 8'h01, 1'b0},  // R1
    {1'b0, 24'h000205, 8'h00, 8'h01, 1'b0},  // R1
    {1'b0, 24'h000003, 8'h00, 8'h00, 1'b0},  // R2
    {1'b0, 24'h0005FF, 8'h00, 8'h00, 1'b0},  // R2
    {1'b0, 24'h000600, 8'h00, 8'h00, 1'b1},  // R6
    {1'b0, 24'h07FFFF, 8'h00, 8'h00, 1'b1},  // R6
    {1'b1, 24'h000001, 8'h0A, 8'h00, 1'b0},  // R5 preset overwrite
    {1'b0, 24'h000001, 8'h00, 8'h0A, 1'b0},  // R5 / R4
    {1'b1, 24'h0005FF, 8'hA5, 8'h00, 1'b0},  // R5 window top
    {1'b0, 24'h0005FF, 8'h00, 8'hA5, 1'b0},  // R4
    {1'b1, 24'h000600, 8'h33, 8'h00, 1'b1},  // R7
    {1'b1, 24'h100005, 8'h55, 8'h00, 1'b1},  // R8 / R7
    {1'b0, 24'h100005, 8'h00, 8'h00, 1'b1},  // R8
    {1'b0, 24'h000005, 8'h00, 8'h00, 1'b0},  // R7 alias untouched
    {1'b0, 24'h000000, 8'h00, 8'h10, 1'b0}   // R7 alias untouched
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R3 watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R11: outputs held quiet during reset
    check(ackValid == 1'b0 && ackErr == 1'b0 && ackRdata == 8'h00, "R11",
          "reset outputs", {23'd0, ackValid, ackErr, ackRdata}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R4 vec%0d", i);
      access(VECS[i][41], VECS[i][40:17], VECS[i][16:9], VECS[i][8:1], VECS[i][0], tag);
    end

    // R3: no acknowledge while idle
    @(negedge clk);
    check(ackValid == 1'b0, "R3", "idle ackValid", 32'(ackValid), 32'h0);

    // R9 / R10: write then read back-to-back, err pulse lasts one cycle
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 24'h000700; reqWdata = 8'h11;
    @(negedge clk);
    check(ackErr == 1'b1, "R9", "err pulse", 32'(ackErr), 32'h1);
    reqWrite = 1'b1; reqAddr = 24'h000123; reqWdata = 8'h5C;
    @(negedge clk);
    check(ackErr == 1'b0, "R9", "err single cycle", 32'(ackErr), 32'h0);
    reqWrite = 1'b0; reqAddr = 24'h000123;
    @(negedge clk);
    reqValid = 1'b0;
    check(ackValid && ackRdata == 8'h5C, "R10", "back-to-back read",
          32'(ackRdata), 32'h5C);

    // R11: reset restores the image; read in first cycle after release
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 24'h000001;
    @(negedge clk);
    reqValid = 1'b0;
    check(ackValid && ackRdata == 8'h14, "R11", "preset after reset",
          32'(ackRdata), 32'h14);
    access(1'b0, 24'h0005FF, 8'h00, 8'h00, 1'b0, "R11 cleared");
    access(1'b0, 24'h000123, 8'h00, 8'h00, 1'b0, "R11 cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule